// File: doc/BRIEF.md
# Microprogrammed control sequencer

This block drives the control lines of a small accumulator CPU whose registers share one internal bus. A microprogram counter selects a word in a control store. The control store is a constant table written in the RTL. Each word holds three things: a group of individual control bits, a 3-bit code that names which register drives the bus, and the address of the word to run next. A decoder turns the bus code into one-hot output enables. All other control bits go straight to the outputs.

The store holds two routines. The first is a four-step instruction fetch. The second is a four-step add-to-accumulator execute routine. The last fetch word carries a dispatch flag. When that flag is set, the next address comes from an opcode lookup instead of the word's own next-address field. The opcode input is the opcode field of the instruction word that is on the bus while the instruction register loads. Opcode `010` selects the add routine. Every other opcode returns to fetch. The last execute word points back to the first fetch word. The datapath and the memory sit outside this block.

Top module: `useq_ctrl`

## Requirements
- R1: While rst_ni is low, every output is 0. From the first rising clock edge after rst_ni goes high, the outputs show the first fetch step.
- R2: In fetch step T0, bus_oe_o is 00010 (PC drives the bus) and mar_ld_o is 1. All other outputs are 0.
- R3: In T1, mem_rd_o and pc_inc_o are 1. In T2, mdr_ld_o is 1. All other outputs in these two steps are 0.
- R4: In T3, bus_oe_o is 00100 (the read data register drives the bus) and ir_ld_o is 1. This step dispatches on opcode_i.
- R5: If opcode_i is 010 at T3, the next step is T4. For any other opcode, the next step is T0.
- R6: In T4, bus_oe_o is 00001 (IR drives the bus) and y_ld_o is 1.
- R7: In T5, bus_oe_o is 01000 (ACC drives the bus) and alu_op_o is 01 (add). In T6, z_ld_o is 1 and alu_op_o is 00. In T7, bus_oe_o is 10000 (Z drives the bus) and acc_ld_o is 1. The step after T7 is T0.
- R8: At most one bit of bus_oe_o is 1 in any cycle. The bit order is 0 IR, 1 PC, 2 read data register, 3 ACC, 4 Z. Source code 000 drives nothing, codes 001 to 101 select the sources in that bit order, and codes 110 and 111 also drive nothing.
- R9: mem_wr_o stays 0 in every step of the supplied routines.
- R10: With a simple datapath attached, running ADD n adds the 13-bit operand n to ACC. A non-add opcode leaves ACC unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| opcode_i | input | 3 | Opcode field of the word being loaded into IR |
| bus_oe_o | output | 5 | One-hot bus source enables (IR, PC, read data reg, ACC, Z) |
| mar_ld_o | output | 1 | Load memory address register from bus |
| mem_rd_o | output | 1 | Memory read request |
| mem_wr_o | output | 1 | Memory write request |
| mdr_ld_o | output | 1 | Capture memory data into read data register |
| ir_ld_o | output | 1 | Load IR from bus |
| y_ld_o | output | 1 | Load Y from bus |
| z_ld_o | output | 1 | Load Z from ALU result |
| acc_ld_o | output | 1 | Load ACC from bus |
| pc_inc_o | output | 1 | Increment PC |
| alu_op_o | output | 2 | ALU operation: 00 pass, 01 add, 10 and, 11 not |

## Verification
All outputs are combinational from the registered microprogram counter. Each step's control word is therefore visible for the whole cycle that follows the rising edge that entered that step. The bench compares the full output word at every falling edge, one step per clock. It checks T0 on the first falling edge after the release edge, and it checks the dispatch result one cycle after T3. The bench's datapath model updates on rising edges. So ACC is read just after the edge that ends T7, before the next fetch word is sampled.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int UPC_W = 3;
  localparam int SRC_W = 3;
  localparam int NSRC  = 5;
  localparam int OP_W  = 3;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0, ALU_ADD = 2'd1, ALU_AND = 2'd2, ALU_NOT = 2'd3
  } alu_op_e;

  // vertical bus-source code; 6,7 unused -> no driver
  typedef enum logic [SRC_W-1:0] {
    SRC_NONE = 3'd0, SRC_IR = 3'd1, SRC_PC = 3'd2,
    SRC_MDR  = 3'd3, SRC_ACC = 3'd4, SRC_Z = 3'd5
  } src_e;

  typedef struct packed {
    logic [UPC_W-1:0] next;
    logic             dispatch;
    src_e             src;
    logic             mar_ld;
    logic             mem_rd;
    logic             mem_wr;
    logic             mdr_ld;
    logic             ir_ld;
    logic             y_ld;
    logic             z_ld;
    logic             acc_ld;
    logic             pc_inc;
    alu_op_e          alu_op;
  } uword_t;
endpackage

// File: rtl/ctrl_store.sv
module ctrl_store
  import useq_pkg::*;
(
  input  logic [UPC_W-1:0] upc_i,
  output uword_t           word_o
);
  always_comb begin
    word_o = '0;
    case (upc_i)
      UPC_W'(0): begin word_o.src = SRC_PC;  word_o.mar_ld = 1'b1; word_o.next = UPC_W'(1); end
      UPC_W'(1): begin word_o.mem_rd = 1'b1; word_o.pc_inc = 1'b1; word_o.next = UPC_W'(2); end
      UPC_W'(2): begin word_o.mdr_ld = 1'b1; word_o.next = UPC_W'(3); end
      UPC_W'(3): begin word_o.src = SRC_MDR; word_o.ir_ld = 1'b1; word_o.dispatch = 1'b1; end
      UPC_W'(4): begin word_o.src = SRC_IR;  word_o.y_ld = 1'b1; word_o.next = UPC_W'(5); end
      UPC_W'(5): begin word_o.src = SRC_ACC; word_o.alu_op = ALU_ADD; word_o.next = UPC_W'(6); end
      UPC_W'(6): begin word_o.z_ld = 1'b1;   word_o.next = UPC_W'(7); end
      UPC_W'(7): begin word_o.src = SRC_Z;   word_o.acc_ld = 1'b1; word_o.next = UPC_W'(0); end
      default:   word_o = '0;
    endcase
  end
endmodule

// File: rtl/bus_src_dec.sv
module bus_src_dec #(
  parameter int SRC_W = 3,
  parameter int NSRC  = 5
) (
  input  logic [SRC_W-1:0] code_i,
  output logic [NSRC-1:0]  oe_o
);
  for (genvar g = 0; g < NSRC; g++) begin : g_oe
    assign oe_o[g] = (code_i == SRC_W'(g + 1));
  end

  // R8
  always_comb begin
    src_onehot_chk: assert ($onehot0(oe_o));
  end
endmodule

// File: rtl/useq_seq.sv
module useq_seq
  import useq_pkg::*;
#(
  parameter logic [OP_W-1:0]  ADD_OP      = 3'b010,
  parameter logic [UPC_W-1:0] ADD_ENTRY   = 3'd4,
  parameter logic [UPC_W-1:0] FETCH_ENTRY = 3'd0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dispatch_i,
  input  logic [UPC_W-1:0] next_i,
  input  logic [OP_W-1:0]  opcode_i,
  output logic [UPC_W-1:0] upc_o,
  output logic             run_o
);
  logic [UPC_W-1:0] upc_q, disp_addr, upc_d;

  always_comb begin
    case (opcode_i)
      ADD_OP:  disp_addr = ADD_ENTRY;
      default: disp_addr = FETCH_ENTRY;
    endcase
  end

  assign upc_d = dispatch_i ? disp_addr : next_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upc_q <= FETCH_ENTRY;
      run_o <= 1'b0;
    end else begin
      run_o <= 1'b1;
      if (run_o) upc_q <= upc_d;
    end
  end

  assign upc_o = upc_q;
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] opcode_i,
  output logic [NSRC-1:0] bus_oe_o,
  output logic            mar_ld_o,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic            mdr_ld_o,
  output logic            ir_ld_o,
  output logic            y_ld_o,
  output logic            z_ld_o,
  output logic            acc_ld_o,
  output logic            pc_inc_o,
  output logic [1:0]      alu_op_o
);
  logic [UPC_W-1:0] upc;
  logic             run;
  uword_t           word, word_g;

  useq_seq u_seq (
    .clk_i, .rst_ni,
    .dispatch_i (word_g.dispatch),
    .next_i     (word_g.next),
    .opcode_i,
    .upc_o      (upc),
    .run_o      (run)
  );

  ctrl_store u_store (.upc_i(upc), .word_o(word));

  assign word_g = run ? word : '0;

  bus_src_dec #(.SRC_W(SRC_W), .NSRC(NSRC)) u_dec (
    .code_i (word_g.src),
    .oe_o   (bus_oe_o)
  );

  assign mar_ld_o = word_g.mar_ld;
  assign mem_rd_o = word_g.mem_rd;
  assign mem_wr_o = word_g.mem_wr;
  assign mdr_ld_o = word_g.mdr_ld;
  assign ir_ld_o  = word_g.ir_ld;
  assign y_ld_o   = word_g.y_ld;
  assign z_ld_o   = word_g.z_ld;
  assign acc_ld_o = word_g.acc_ld;
  assign pc_inc_o = word_g.pc_inc;
  assign alu_op_o = word_g.alu_op;

  // R3
  rd_then_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> mdr_ld_o);
  // R5
  add_dispatch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ir_ld_o && opcode_i == 3'b010) |=> (y_ld_o && bus_oe_o == 5'b00001));
  // R5
  other_dispatch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ir_ld_o && opcode_i != 3'b010) |=> (mar_ld_o && bus_oe_o == 5'b00010));
  // R7
  z_to_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_ld_o |=> (acc_ld_o && bus_oe_o == 5'b10000));
  // R7
  acc_to_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ld_o |=> mar_ld_o);
endmodule

// File: tb/sim_useq_ctrl.sv
module sim_useq_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0]  opcode;
  logic [4:0]  bus_oe;
  logic mar_ld, mem_rd, mem_wr, mdr_ld, ir_ld, y_ld, z_ld, acc_ld, pc_inc;
  logic [1:0]  alu_op;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  useq_ctrl u0 (
    .clk_i(clk), .rst_ni, .opcode_i(opcode), .bus_oe_o(bus_oe),
    .mar_ld_o(mar_ld), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mdr_ld_o(mdr_ld),
    .ir_ld_o(ir_ld), .y_ld_o(y_ld), .z_ld_o(z_ld), .acc_ld_o(acc_ld),
    .pc_inc_o(pc_inc), .alu_op_o(alu_op)
  );

  // {bus_oe, mar, rd, wr, mdr, ir, y, z, acc, pc_inc, alu_op}
  localparam logic [15:0] W_ZERO = 16'b00000_000000000_00;
  localparam logic [15:0] W_T0   = 16'b00010_100000000_00;
  localparam logic [15:0] W_T1   = 16'b00000_010000001_00;
  localparam logic [15:0] W_T2   = 16'b00000_000100000_00;
  localparam logic [15:0] W_T3   = 16'b00100_000010000_00;
  localparam logic [15:0] W_T4   = 16'b00001_000001000_00;
  localparam logic [15:0] W_T5   = 16'b01000_000000000_01;
  localparam logic [15:0] W_T6   = 16'b00000_000000100_00;
  localparam logic [15:0] W_T7   = 16'b10000_000000010_00;

  logic [15:0] outw;
  assign outw = {bus_oe, mar_ld, mem_rd, mem_wr, mdr_ld, ir_ld, y_ld, z_ld,
                 acc_ld, pc_inc, alu_op};

  // simple datapath model
  logic [15:0] mem [8];
  logic [12:0] pc, mar;
  logic [15:0] mdr, ir, y, z, acc, alu_r, bus;
  always_comb begin
    bus = '0;
    case (bus_oe)
      5'b00001: bus = ir;
      5'b00010: bus = {3'b000, pc};
      5'b00100: bus = mdr;
      5'b01000: bus = acc;
      5'b10000: bus = z;
      default:  bus = '0;
    endcase
  end
  assign opcode = mdr[15:13];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pc <= '0; mar <= '0; mdr <= '0; ir <= '0; y <= '0; z <= '0;
      acc <= '0; alu_r <= '0;
    end else begin
      if (mar_ld) mar <= bus[12:0];
      if (pc_inc) pc <= pc + 13'd1;
      if (mdr_ld) mdr <= mem[mar[2:0]];
      if (ir_ld)  ir <= bus;
      if (y_ld)   y <= {3'b000, bus[12:0]};
      if (alu_op == 2'b01) alu_r <= bus + y;
      if (z_ld)   z <= alu_r;
      if (acc_ld) acc <= bus;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [15:0] exp);
    @(negedge clk);
    chk(tag, outw, exp);
    chk("R8", 16'($countones(bus_oe) <= 1), 16'd1);
    chk("R9", {15'd0, mem_wr}, 16'd0);
  endtask

  task automatic t_reset();
    repeat (3) begin
      @(negedge clk);
      chk("R1 reset", outw, W_ZERO);
    end
    rst_ni = 1'b1;
  endtask

  task automatic t_fetch();
    step("R1/R2 T0", W_T0);
    step("R3 T1", W_T1);
    step("R3 T2", W_T2);
    step("R4 T3", W_T3);
  endtask

  task automatic t_add(input logic [15:0] exp_acc);
    t_fetch();
    step("R5/R6 T4", W_T4);
    step("R7 T5", W_T5);
    step("R7 T6", W_T6);
    step("R7 T7", W_T7);
    @(posedge clk); #1;
    chk("R10 acc", acc, exp_acc);
  endtask

  task automatic t_other(input logic [15:0] exp_acc);
    t_fetch();
    step("R5 back to T0", W_T0);
    chk("R10 acc kept", acc, exp_acc);
    step("R3 T1", W_T1);
    step("R3 T2", W_T2);
    step("R4 T3", W_T3);
  endtask

  initial begin
    mem[0] = 16'h4007; mem[1] = 16'h6000; mem[2] = 16'h4005; mem[3] = 16'h0003;
    mem[4] = 16'h4100; mem[5] = 16'h0; mem[6] = 16'h0; mem[7] = 16'h0;
    t_reset();
    t_add(16'd7);
    t_other(16'd7);
    // remainder of word 2 (ADD 5) after its fetch was checked
    step("R5/R6 T4", W_T4);
    step("R7 T5", W_T5);
    step("R7 T6", W_T6);
    step("R7 T7", W_T7);
    @(posedge clk); #1;
    chk("R10 acc", acc, 16'd12);
    t_other(16'd12);
    step("R5/R6 T4", W_T4);
    step("R7 T5", W_T5);
    step("R7 T6", W_T6);
    step("R7 T7", W_T7);
    @(posedge clk); #1;
    chk("R10 acc", acc, 16'd268);
    step("R7 return T0", W_T0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule